// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block takes an erase request, given as a byte start address and a byte length, and carries it out on a serial flash device over a mode-0 SPI link. It first divides both numbers by the configured page size. If both divide evenly, it walks the page range from low to high. At each step it issues either a single-page erase or an eight-page block erase, then polls the device status register until the device reports ready. Only then does it move on.

Page sizes need not be powers of two. The page index is placed into the flash address by a configurable left shift, so a 264-byte page can sit behind a 9-bit shift. A request whose address or length is not page aligned is refused before any bus traffic. A page size of zero is refused in the same way. The host sees `busy` while a request runs, and then a single-cycle `done` or `error` pulse.

Top module: `flash_erase_seq`

## Requirements
- R1: When `page_bytes` is zero, or when the start address or the length is not a whole multiple of `page_bytes`, `error` pulses high for exactly one cycle. No SPI frame is sent (`cs_n` stays high) and `done` does not pulse.
- R2: The first byte of each erase frame is the opcode: 0x50 for an eight-page block erase and 0x81 for a single-page erase.
- R3: Block erase is used only when the current page index has bits [2:0] equal to zero and at least eight pages remain. In every other case page erase is used.
- R4: An erase frame is 32 bits, sent MSB first. It holds the opcode, then bits [23:16] of the flash address, then bits [15:8], then a 0x00 byte. The flash address is the page index shifted left by `page_shift`.
- R5: After every erase frame the block sends 16-bit status frames. Each starts with opcode 0xD7, and the second byte is the status read from `miso`. Polling repeats until status bit 7 reads 1. No erase frame is sent before that ready status has been seen.
- R6: A block erase advances the page index and reduces the remaining count by eight. A page erase changes each by one. The erase frames cover exactly the requested range, in ascending order.
- R7: `cs_n` stays high for at least 2*HALF clock cycles (one SCLK period) between any two frames.
- R8: Between two consecutive status frames, `cs_n` stays high for at least `poll_gap` + 2*HALF clock cycles.
- R9: `busy` is high from the cycle after an accepted `start` until the cycle `done` or `error` pulses. `done` is one cycle wide, and `busy` is low in that same cycle. A zero-length request gives `done` with no SPI frame.
- R10: SPI mode 0 applies. `sclk` is low whenever `cs_n` is high. Each SCLK phase lasts HALF clock cycles. `mosi` changes only on falling SCLK edges, and `miso` is taken on rising edges.
- R11: `start` is ignored while `busy` is high. The running request completes with its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| start_addr | input | AW | Byte start address |
| erase_len | input | AW | Byte length |
| page_bytes | input | PW | Page size in bytes |
| page_shift | input | 4 | Left shift of page index into flash address |
| poll_gap | input | GW | Extra idle cycles between status polls |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to device |
| miso | input | 1 | SPI data from device |
| cs_n | output | 1 | SPI chip select, active low |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |

## Verification
A corrupted page index or remaining count shows up at the pins as a wrong opcode or wrong address bytes in the very next erase frame. It can also show up as a command list that is too long or too short by the time `done` fires. A wrong poll decision appears within one status frame, either as an erase frame sent while the device still reports busy, or as a poll count that does not match the replies. A broken gap or frame counter changes `cs_n` spacing or frame length at the very next frame boundary.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int AW   = 24,
  parameter int PW   = 12,
  parameter int GW   = 16,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] erase_len,
  input  logic [PW-1:0] page_bytes,
  input  logic [3:0]    page_shift,
  input  logic [GW-1:0] poll_gap,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          cs_n,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam int CW  = $clog2(AW + 1);
  localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int GCW = $clog2(2 * HALF) + 1;

  typedef enum logic [2:0] {S_IDLE, S_DIVA, S_DIVL, S_GAP, S_CMD, S_POLL, S_WAIT} st_t;
  st_t st;

  logic [AW-1:0]  q, pidx, left;
  logic [PW-1:0]  r, pb;
  logic [CW-1:0]  dcnt;
  logic [3:0]     sh;
  logic [GW-1:0]  pgap, wcnt;
  logic [31:0]    tx;
  logic [7:0]     rx;
  logic [HCW-1:0] hcnt;
  logic [GCW-1:0] gcnt;
  logic [4:0]     bcnt;
  logic           sclk_r, blk, to_poll;

  logic [PW:0]    rsh, rnx;
  logic           ge;
  logic [AW-1:0]  qnx;
  assign rsh = {r, q[AW-1]};
  assign ge  = rsh >= {1'b0, pb};
  assign rnx = ge ? rsh - {1'b0, pb} : rsh;
  assign qnx = {q[AW-2:0], ge};

  logic [AW+23:0] wide;
  logic [23:0]    faddr;
  logic           blk_ok;
  logic [AW-1:0]  step, left_nx;
  assign wide    = {24'd0, pidx} << sh;
  assign faddr   = wide[23:0];
  assign blk_ok  = (pidx[2:0] == 3'd0) && (left >= AW'(8));
  assign step    = blk ? AW'(8) : AW'(1);
  assign left_nx = left - step;

  logic in_frame, edge_t, last_bit;
  assign in_frame = (st == S_CMD) || (st == S_POLL);
  assign edge_t   = hcnt == HCW'(HALF - 1);
  assign last_bit = (st == S_CMD) ? (bcnt == 5'd31) : (bcnt == 5'd15);

  assign sclk  = sclk_r;
  assign cs_n  = !in_frame;
  assign mosi  = in_frame & tx[31];
  assign busy  = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; r <= '0; dcnt <= '0; pidx <= '0; left <= '0;
      pb <= '0; sh <= '0; pgap <= '0; wcnt <= '0; tx <= '0; rx <= '0;
      hcnt <= '0; gcnt <= '0; bcnt <= '0; sclk_r <= 1'b0; blk <= 1'b0;
      to_poll <= 1'b0; done <= 1'b0; error <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pb <= page_bytes; sh <= page_shift; pgap <= poll_gap;
          q <= start_addr; r <= '0; dcnt <= '0; left <= erase_len;
          if (page_bytes == '0) error <= 1'b1;
          else st <= S_DIVA;
        end
        S_DIVA, S_DIVL: begin
          q <= qnx; r <= rnx[PW-1:0]; dcnt <= dcnt + 1'b1;
          if (dcnt == CW'(AW - 1)) begin
            dcnt <= '0;
            if (rnx != '0) begin
              error <= 1'b1; st <= S_IDLE;
            end else if (st == S_DIVA) begin
              pidx <= qnx; q <= left; r <= '0; st <= S_DIVL;
            end else if (qnx == '0) begin
              done <= 1'b1; st <= S_IDLE;
            end else begin
              left <= qnx; to_poll <= 1'b0; gcnt <= '0; st <= S_GAP;
            end
          end
        end
        S_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == GCW'(2 * HALF - 1)) begin
            gcnt <= '0; hcnt <= '0; bcnt <= '0; sclk_r <= 1'b0;
            if (to_poll) begin
              tx <= {8'hD7, 24'h0}; st <= S_POLL;
            end else begin
              tx  <= {blk_ok ? 8'h50 : 8'h81, faddr[23:16], faddr[15:8], 8'h00};
              blk <= blk_ok; st <= S_CMD;
            end
          end
        end
        S_CMD, S_POLL: begin
          hcnt <= hcnt + 1'b1;
          if (edge_t) begin
            hcnt <= '0;
            if (!sclk_r) begin
              sclk_r <= 1'b1; rx <= {rx[6:0], miso};
            end else begin
              sclk_r <= 1'b0; tx <= {tx[30:0], 1'b0}; bcnt <= bcnt + 1'b1;
              if (last_bit) begin
                if (st == S_CMD) begin
                  to_poll <= 1'b1; st <= S_GAP;
                end else if (!rx[7]) begin
                  wcnt <= '0; st <= S_WAIT;
                end else begin
                  pidx <= pidx + step; left <= left_nx;
                  if (left_nx == '0) begin
                    done <= 1'b1; st <= S_IDLE;
                  end else begin
                    to_poll <= 1'b0; st <= S_GAP;
                  end
                end
              end
            end
          end
        end
        S_WAIT: begin
          if (wcnt >= pgap) st <= S_GAP;
          else wcnt <= wcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic done,
  input logic error
);
  logic [7:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
  end

  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done || error));
  // R1
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) error |-> (!done && cs_n));
  // R1
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) error |=> !error);
  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> (hi_cnt >= 8'(2 * HALF)));
endmodule

bind flash_erase_seq flash_erase_seq_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .busy(busy), .done(done), .error(error)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] start_addr = '0, erase_len = '0;
  logic [11:0] page_bytes = '0;
  logic [3:0]  page_shift = '0;
  logic [15:0] poll_gap = '0;
  logic sclk, mosi, miso, cs_n, busy, done, error;

  always #5 clk = ~clk;

  flash_erase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .erase_len(erase_len), .page_bytes(page_bytes), .page_shift(page_shift),
    .poll_gap(poll_gap), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .busy(busy), .done(done), .error(error)
  );

  int n_chk = 0, n_err = 0;
  int cur_pgap = 0;
  bit abort = 0;

  // device model
  logic miso_r = 1'b0;
  assign miso = miso_r;
  int bcnt = 0, hi_cnt = 0, last_gap = 0;
  int cmd_n = 0, poll_n = 0, frm_n = 0, busy_polls = 0, polls_since = 0;
  int v_order = 0, v_gap7 = 0, v_gap8 = 0, v_len = 0, v_idle = 0;
  bit ready_seen = 1, prev_poll = 0;
  logic [7:0] sh_in = '0, sbyte = '0;
  logic [7:0] fb [4];
  logic [7:0] c_op [1024];
  logic [7:0] c_a1 [1024];
  logic [7:0] c_a2 [1024];
  logic [7:0] c_a3 [1024];

  always @(negedge clk) begin
    hi_cnt = cs_n ? hi_cnt + 1 : 0;
    if (cs_n && sclk) v_idle++;
  end
  always @(negedge cs_n) begin bcnt = 0; last_gap = hi_cnt; end
  always @(posedge sclk) if (!cs_n) begin
    sh_in = {sh_in[6:0], mosi};
    bcnt++;
    if (bcnt % 8 == 0 && bcnt <= 32) fb[bcnt/8-1] = sh_in;
    if (bcnt == 8 && sh_in == 8'hD7) sbyte = (polls_since >= busy_polls) ? 8'hAC : 8'h2C;
  end
  always @(negedge sclk) if (!cs_n && bcnt >= 8 && bcnt < 16) miso_r = sbyte[15-bcnt];
  always @(posedge cs_n) if (bcnt > 0) begin
    frm_n++;
    if (last_gap < 4) v_gap7++;
    if (bcnt == 32 && fb[0] != 8'hD7) begin
      if (!ready_seen) v_order++;
      if (cmd_n < 1024) begin
        c_op[cmd_n] = fb[0]; c_a1[cmd_n] = fb[1]; c_a2[cmd_n] = fb[2]; c_a3[cmd_n] = fb[3];
      end
      cmd_n++;
      busy_polls = cmd_n % 3; polls_since = 0; ready_seen = 0; prev_poll = 0;
    end else if (bcnt == 16 && fb[0] == 8'hD7) begin
      if (prev_poll && last_gap < cur_pgap + 4) v_gap8++;
      if (sbyte[7]) ready_seen = 1;
      polls_since++; poll_n++; prev_poll = 1;
    end else begin
      v_len++; prev_poll = 0;
    end
    bcnt = 0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int a, input int l, input int p, input int s, input bit ovr);
    int b_cmd, b_poll, b_frm, b_o, b_g7, b_g8, b_len, b_idle, t, sp, np, k, pexp;
    bit exp_err, saw_done, saw_err;
    if (abort) return;
    exp_err = (p == 0) || (a % (p == 0 ? 1 : p) != 0) || (l % (p == 0 ? 1 : p) != 0);
    b_cmd = cmd_n; b_poll = poll_n; b_frm = frm_n; b_o = v_order; b_g7 = v_gap7;
    b_g8 = v_gap8; b_len = v_len; b_idle = v_idle;
    cur_pgap = 5;
    @(negedge clk);
    start_addr = 24'(a); erase_len = 24'(l); page_bytes = 12'(p);
    page_shift = 4'(s); poll_gap = 16'(cur_pgap); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (p != 0) chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    t = 0;
    while (!(done || error) && t < 40000) begin
      @(negedge clk);
      t++;
      if (ovr && t == 30) begin start = 1'b1; start_addr = 24'(a + 1); erase_len = 24'd1; end
      else start = 1'b0;
    end
    start = 1'b0;
    if (t >= 40000) begin
      chk(0, "R9", "request never finished", t, 0);
      abort = 1;
      return;
    end
    saw_done = done; saw_err = error;
    chk(!busy, "R9", "busy low at end pulse", busy, 0);
    @(negedge clk);
    chk(!done && !error, "R9", "end pulse one cycle", {done, error}, 0);
    if (exp_err) begin
      chk(saw_err && !saw_done, "R1", "rejection pulse", {saw_err, saw_done}, 2);
      chk(frm_n == b_frm, "R1", "frames on rejected request", frm_n - b_frm, 0);
      return;
    end
    chk(saw_done && !saw_err, ovr ? "R11" : "R9", "done on good request", {saw_done, saw_err}, 2);
    sp = a / p; np = l / p; k = 0; pexp = 0;
    while (np > 0) begin
      bit bk;
      int fa;
      bk = (sp % 8 == 0) && (np >= 8);
      fa = (sp << s) & 24'hFFFFFF;
      if (b_cmd + k < 1024) begin
        chk(c_op[b_cmd+k] == (bk ? 8'h50 : 8'h81), "R2/R3", "opcode", c_op[b_cmd+k], bk ? 8'h50 : 8'h81);
        chk({c_a1[b_cmd+k], c_a2[b_cmd+k], c_a3[b_cmd+k]} == {8'(fa >> 16), 8'(fa >> 8), 8'h00},
            "R4", "address bytes", {c_a1[b_cmd+k], c_a2[b_cmd+k], c_a3[b_cmd+k]}, {8'(fa >> 16), 8'(fa >> 8), 8'h00});
      end
      pexp += (b_cmd + k + 1) % 3 + 1;
      sp += bk ? 8 : 1; np -= bk ? 8 : 1; k++;
    end
    chk(cmd_n - b_cmd == k, ovr ? "R11" : "R6", "erase command count", cmd_n - b_cmd, k);
    chk(poll_n - b_poll == pexp, "R5", "status poll count", poll_n - b_poll, pexp);
    chk(v_order == b_o, "R5", "erase before ready", v_order - b_o, 0);
    chk(v_gap7 == b_g7, "R7", "short cs gap", v_gap7 - b_g7, 0);
    chk(v_gap8 == b_g8, "R8", "short poll interval", v_gap8 - b_g8, 0);
    chk(v_len == b_len && v_idle == b_idle, "R10", "frame length / idle sclk", v_len - b_len + v_idle - b_idle, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
      $finish;
    end
  end

  initial begin
    int sps[5] = '{0, 3, 7, 8, 13};
    int nps[7] = '{0, 1, 7, 8, 9, 16, 17};
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk, "R10", "reset bus idle", {cs_n, sclk}, 2);
    chk(!busy && !done && !error, "R9", "reset outputs", {busy, done, error}, 0);
    rst_n = 1'b1;
    foreach (sps[i]) foreach (nps[j]) run(sps[i] * 264, nps[j] * 264, 264, 9, 0);
    run(8 * 528, 9 * 528, 528, 10, 0);
    run(16 * 1056, 24 * 1056, 1056, 11, 0);
    run(15 * 1056, 10 * 1056, 1056, 11, 0);
    run(32760 * 264, 8 * 264, 264, 9, 0);
    run(264 + 1, 2 * 264, 264, 9, 0);
    run(2 * 264, 2 * 264 + 5, 264, 9, 0);
    run(0, 264, 0, 9, 0);
    run(3 * 528, 4 * 528 + 1, 528, 10, 0);
    run(5 * 264, 12 * 264, 264, 9, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule